// File: doc/BRIEF.md
# Secondary Interrupt Source Bank

This block gathers up to a few dozen peripheral event inputs and turns selected transitions on them into latched interrupt status. Every input is first brought into the clock domain through a two-stage synchroniser. A shared edge-select table then decides, per source, whether a rising edge, a falling edge, either edge or no edge is an event. Each event is latched into two independent status copies, one for each host. Each host has its own mask copy and its own active-low interrupt output, so two masters can each service the sources they own without disturbing the other.

Software reaches the block through a byte-wide register port. Multi-byte fields are laid out little-endian, with the lowest-numbered sources in the lowest address. The block uses this map:

- line 0 status at 0x00 and line 0 mask at 0x04
- line 1 status at 0x08 and line 1 mask at 0x0C
- edge-select table at 0x10
- force register at 0x18
- control byte at 0x1C

A control bit chooses how status is cleared. In read-clears mode, reading a status byte clears the bits it returned. In write-ones mode, writing a one to a status bit clears it. A second control bit turns off the one-deep buffer that keeps a repeat event which arrives while its status bit is still set.

Top module: `sec_irq_bank`

## Requirements
- R1: After reset both `irq_n` outputs are high. All status bits read 0 and all mask bits read 1. Mask bytes return 0xFF, 0xFF, 0x03 for 18 sources, because bits above the last source read 0. The edge-select table and the control byte read 0.
- R2: Source i owns edge-select byte 0x10+(i>>2), at bits (i&3)*2+1 (rising) and (i&3)*2 (falling). Setting both bits detects either edge. A change on the input, applied before a clock edge, is visible in status and on `irq_n` after the third rising clock edge.
- R3: A source whose two edge-select bits are both 0 never sets its status bit on either line, whatever its input does.
- R4: `irq_n[l]` is low exactly while some source has status 1 and mask 0 on line l. A masked source still latches its status, and that status can be read back.
- R5: An event sets the status bit on both lines. Clearing or masking a bit on one line leaves the other line's status and output untouched.
- R6: When control bit 0 (clear-on-read) is 1, reading a status byte returns its bits and then clears them. Writes to status bytes have no effect in this mode.
- R7: When control bit 0 is 0, reads do not change status. Writing 1 to a status bit clears it, and writing 0 leaves it as it is.
- R8: When control bit 1 (exclusive) is 0, an event on a bit whose status is already set is held. When that bit is next cleared, it stays set, so a second read still returns it. When control bit 1 is 1, nothing is held and the second read returns 0.
- R9: Writing a 1 to a bit of the force register at 0x18 (little-endian over the sources) sets that source's status on both lines, in the cycle after the write.
- R10: If a clear and a new event hit the same status bit in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | NSRC | Raw, asynchronous event inputs |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe; in clear-on-read mode the clear takes effect at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 2 | Active-low interrupt outputs, one per host line |

## Verification
Several rules are checked by assertions on every cycle:

- an event or a force sets its status bit in the next cycle
- a clear with nothing pending and no new event takes effect
- a held event re-arms its bit when that bit is cleared
- exclusive mode leaves nothing held
- a source with a zero edge field never raises its status
- a line whose mask bits are all set keeps its output high

Some behaviour can only be shown by the directed scenarios: the three-edge input latency, the edge-select bit positions, the byte layout of each field, and the difference between the two clear modes as seen through reads. The same holds for line independence and for the exact cycle in which a clear and a new edge collide.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;
  localparam logic [7:0] A_ST0   = 8'h00;
  localparam logic [7:0] A_MK0   = 8'h04;
  localparam logic [7:0] A_ST1   = 8'h08;
  localparam logic [7:0] A_MK1   = 8'h0C;
  localparam logic [7:0] A_EDGE  = 8'h10;
  localparam logic [7:0] A_FORCE = 8'h18;
  localparam logic [7:0] A_CTRL  = 8'h1C;
  localparam int unsigned CTRL_COR  = 0;
  localparam int unsigned CTRL_EXCL = 1;
  localparam int unsigned NLINES = 2;
endpackage

// File: rtl/sec_irq_edge.sv
module sec_irq_edge #(
  parameter int unsigned NSRC = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] rise_en,
  input  logic [NSRC-1:0] fall_en,
  output logic [NSRC-1:0] ev
);
  logic [NSRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    ev = (sync_q & ~prev_q & rise_en) | (~sync_q & prev_q & fall_en);
  end
endmodule

// File: rtl/sec_irq_line.sv
module sec_irq_line #(
  parameter int unsigned NSRC = 18,
  parameter int unsigned NB   = (NSRC + 7) / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] force_set,
  input  logic            cor,
  input  logic            excl,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [NB-1:0]   st_sel,
  input  logic [NB-1:0]   mk_sel,
  input  logic [7:0]      wdata,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic            irq_n
);
  logic [NSRC-1:0] st_q, st_n, pd_q, pd_n, msk_q, msk_n, clr, hit;
  logic            mk_we;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    localparam int unsigned BY = i / 8;
    localparam int unsigned BI = i % 8;
    assign clr[i]   = cor ? (rd_en & st_sel[BY]) : (wr_en & st_sel[BY] & wdata[BI]);
    assign msk_n[i] = mk_sel[BY] ? wdata[BI] : msk_q[i];
  end

  assign mk_we = wr_en & (|mk_sel);

  always_comb begin
    hit  = ev | force_set;
    st_n = (st_q & ~clr) | hit | (clr & pd_q);
    if (excl) begin
      pd_n = '0;
    end else begin
      pd_n = (pd_q & ~clr) | (st_q & ~clr & hit) | (clr & pd_q & hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      pd_q  <= '0;
      msk_q <= '1;
    end else begin
      st_q <= st_n;
      pd_q <= pd_n;
      if (mk_we) begin
        msk_q <= msk_n;
      end
    end
  end

  assign status = st_q;
  assign mask   = msk_q;
  assign irq_n  = ~(|(st_q & ~msk_q));

  // R9 R2
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((st_q & $past(hit)) == $past(hit)));

  // R6 R7
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~pd_q & ~hit)) |=> ((st_q & $past(clr & ~pd_q & ~hit)) == '0));

  // R8
  pend_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & pd_q)) |=> ((st_q & $past(clr & pd_q)) == $past(clr & pd_q)));

  // R8
  excl_nobuf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excl |=> (pd_q == '0));
endmodule

// File: rtl/sec_irq_bank.sv
module sec_irq_bank
  import sec_irq_pkg::*;
#(
  parameter int unsigned NSRC = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [7:0]      addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic [1:0]      irq_n
);
  localparam int unsigned NB = (NSRC + 7) / 8;
  localparam int unsigned NE = (2 * NSRC + 7) / 8;
  localparam int unsigned EW = 2 * NSRC;

  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic [EW-1:0]      edr_q, edr_n;
  logic               edr_we;
  logic               cor_q, excl_q;
  logic               ctrl_we;
  logic [NSRC-1:0]    rise_en, fall_en, ev, force_set;
  logic [NE-1:0]      edr_sel;
  logic [NB-1:0]      frc_sel;
  logic [1:0][NB-1:0] st_sel, mk_sel;
  logic [1:0][NSRC-1:0] st_v, mk_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  for (genvar b = 0; b < NE; b++) begin : g_esel
    assign edr_sel[b] = (addr == A_EDGE + 8'(b));
  end
  for (genvar b = 0; b < NB; b++) begin : g_bsel
    assign frc_sel[b]   = (addr == A_FORCE + 8'(b));
    assign st_sel[0][b] = (addr == A_ST0 + 8'(b));
    assign st_sel[1][b] = (addr == A_ST1 + 8'(b));
    assign mk_sel[0][b] = (addr == A_MK0 + 8'(b));
    assign mk_sel[1][b] = (addr == A_MK1 + 8'(b));
  end

  for (genvar j = 0; j < EW; j++) begin : g_edr
    assign edr_n[j] = edr_sel[j / 8] ? wdata[j % 8] : edr_q[j];
  end
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rise_en[i]   = edr_q[2*i+1];
    assign fall_en[i]   = edr_q[2*i];
    assign force_set[i] = wr_en & frc_sel[i / 8] & wdata[i % 8];
  end

  assign edr_we  = wr_en & (|edr_sel);
  assign ctrl_we = wr_en & (addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      edr_q  <= '0;
      cor_q  <= 1'b0;
      excl_q <= 1'b0;
    end else begin
      if (edr_we) begin
        edr_q <= edr_n;
      end
      if (ctrl_we) begin
        cor_q  <= wdata[CTRL_COR];
        excl_q <= wdata[CTRL_EXCL];
      end
    end
  end

  sec_irq_edge #(.NSRC(NSRC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .src     (src_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .ev      (ev)
  );

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    sec_irq_line #(.NSRC(NSRC), .NB(NB)) u_line (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .ev        (ev),
      .force_set (force_set),
      .cor       (cor_q),
      .excl      (excl_q),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .st_sel    (st_sel[l]),
      .mk_sel    (mk_sel[l]),
      .wdata     (wdata),
      .status    (st_v[l]),
      .mask      (mk_v[l]),
      .irq_n     (irq_n[l])
    );
  end

  always_comb begin
    logic [NB*8-1:0] st0_p, st1_p, mk0_p, mk1_p;
    logic [NE*8-1:0] edr_p;
    st0_p = '0; st1_p = '0; mk0_p = '0; mk1_p = '0; edr_p = '0;
    st0_p[NSRC-1:0] = st_v[0];
    st1_p[NSRC-1:0] = st_v[1];
    mk0_p[NSRC-1:0] = mk_v[0];
    mk1_p[NSRC-1:0] = mk_v[1];
    edr_p[EW-1:0]   = edr_q;
    rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr == A_ST0 + 8'(b)) rdata = st0_p[b*8 +: 8];
      if (addr == A_ST1 + 8'(b)) rdata = st1_p[b*8 +: 8];
      if (addr == A_MK0 + 8'(b)) rdata = mk0_p[b*8 +: 8];
      if (addr == A_MK1 + 8'(b)) rdata = mk1_p[b*8 +: 8];
    end
    for (int b = 0; b < NE; b++) begin
      if (addr == A_EDGE + 8'(b)) rdata = edr_p[b*8 +: 8];
    end
    if (addr == A_CTRL) begin
      rdata[CTRL_COR]  = cor_q;
      rdata[CTRL_EXCL] = excl_q;
    end
  end

  // R3
  edge_off_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((st_v[0] & ~$past(st_v[0]) & ~$past(force_set) & ~$past(rise_en | fall_en)) == '0));

  // R4
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (&mk_v[1]) |-> irq_n[1]);
endmodule

// File: tb/tb_sec_irq_bank.sv
module tb_sec_irq_bank;
  localparam int unsigned NSRC = 18;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_in;
  logic [7:0]      addr, wdata, rdata;
  logic            wr_en, rd_en;
  logic [1:0]      irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sec_irq_bank #(.NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic set_src(input int i, input logic val);
    src_in[i] = val;
    tick(3);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq_n", {6'd0, irq_n}, 8'h03);
    for (int b = 0; b < 3; b++) begin
      rd(8'h00 + 8'(b), v); chk("R1 status0", v, 8'h00);
    end
    rd(8'h04, v); chk("R1 mask0 b0", v, 8'hFF);
    rd(8'h0E, v); chk("R1 mask1 b2", v, 8'h03);
    rd(8'h10, v); chk("R1 edge b0", v, 8'h00);
    rd(8'h1C, v); chk("R1 ctrl", v, 8'h00);
  endtask

  task automatic t_edge_sel;
    logic [7:0] v;
    for (int b = 0; b < 3; b++) wr(8'h04 + 8'(b), 8'h00);
    wr(8'h10, 8'h02);
    wr(8'h11, 8'h04);
    wr(8'h14, 8'h0C);
    set_src(1, 1'b1);
    rd(8'h00, v); chk("R3 no-edge source", v, 8'h00);
    chk("R3 irq_n", {7'd0, irq_n[0]}, 8'h01);
    src_in[0] = 1'b1;
    tick(2);
    chk("R2 latency 2 edges", {7'd0, irq_n[0]}, 8'h01);
    tick(1);
    chk("R2 latency 3 edges", {7'd0, irq_n[0]}, 8'h00);
    rd(8'h00, v); chk("R2 rising src0", v, 8'h01);
    rd(8'h00, v); chk("R7 read keeps", v, 8'h01);
    wr(8'h00, 8'h00);
    rd(8'h00, v); chk("R7 zero write keeps", v, 8'h01);
    wr(8'h00, 8'h01);
    rd(8'h00, v); chk("R7 one write clears", v, 8'h00);
    chk("R4 irq_n released", {7'd0, irq_n[0]}, 8'h01);
    set_src(0, 1'b0);
    rd(8'h00, v); chk("R2 rising-only ignores fall", v, 8'h00);
    set_src(5, 1'b1);
    rd(8'h00, v); chk("R2 falling-only ignores rise", v, 8'h00);
    set_src(5, 1'b0);
    rd(8'h00, v); chk("R2 falling src5", v, 8'h20);
    wr(8'h00, 8'h20);
    set_src(17, 1'b1);
    rd(8'h02, v); chk("R2 both rise src17", v, 8'h02);
    wr(8'h02, 8'h02);
    set_src(17, 1'b0);
    rd(8'h02, v); chk("R2 both fall src17", v, 8'h02);
    wr(8'h02, 8'h02);
    for (int b = 0; b < 3; b++) wr(8'h08 + 8'(b), 8'hFF);
  endtask

  task automatic t_lines;
    logic [7:0] v;
    for (int b = 0; b < 3; b++) wr(8'h04 + 8'(b), 8'hFF);
    wr(8'h0C, 8'h00);
    set_src(0, 1'b1);
    chk("R4 masked line quiet", {7'd0, irq_n[0]}, 8'h01);
    chk("R5 line1 asserted", {7'd0, irq_n[1]}, 8'h00);
    rd(8'h00, v); chk("R4 masked status latched", v, 8'h01);
    wr(8'h08, 8'h01);
    chk("R5 line1 cleared", {7'd0, irq_n[1]}, 8'h01);
    rd(8'h00, v); chk("R5 line0 untouched", v, 8'h01);
    wr(8'h00, 8'h01);
  endtask

  task automatic t_cor;
    logic [7:0] v;
    wr(8'h1C, 8'h01);
    set_src(0, 1'b0);
    set_src(0, 1'b1);
    rd(8'h00, v); chk("R6 read returns", v, 8'h01);
    rd(8'h00, v); chk("R6 read cleared", v, 8'h00);
    wr(8'h08, 8'h01);
    rd(8'h08, v); chk("R6 write ignored", v, 8'h01);
    rd(8'h08, v); chk("R6 line1 read cleared", v, 8'h00);
  endtask

  task automatic t_buffer;
    logic [7:0] v;
    wr(8'h1C, 8'h01);
    set_src(17, 1'b1);
    set_src(17, 1'b0);
    rd(8'h02, v); chk("R8 first read", v, 8'h02);
    rd(8'h02, v); chk("R8 buffered second read", v, 8'h02);
    rd(8'h02, v); chk("R8 drained", v, 8'h00);
    rd(8'h0A, v); rd(8'h0A, v);
    wr(8'h1C, 8'h03);
    set_src(17, 1'b1);
    set_src(17, 1'b0);
    rd(8'h02, v); chk("R8 exclusive first read", v, 8'h02);
    rd(8'h02, v); chk("R8 exclusive no buffer", v, 8'h00);
    rd(8'h0A, v);
  endtask

  task automatic t_force;
    logic [7:0] v;
    wr(8'h1C, 8'h00);
    wr(8'h19, 8'h81);
    rd(8'h01, v); chk("R9 force line0", v, 8'h81);
    rd(8'h09, v); chk("R9 force line1", v, 8'h81);
    wr(8'h01, 8'h81);
    wr(8'h09, 8'h81);
    rd(8'h01, v); chk("R9 cleared", v, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(8'h1C, 8'h03);
    set_src(17, 1'b1);
    src_in[17] = 1'b0;
    tick(2);
    addr = 8'h02; rd_en = 1'b1;
    #1 v = rdata;
    chk("R10 before collision", v, 8'h02);
    tick(1);
    rd_en = 1'b0;
    rd(8'h02, v); chk("R10 stays set", v, 8'h02);
    rd(8'h02, v); chk("R10 then clears", v, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_in = '0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_edge_sel();
    t_lines();
    t_cor();
    t_buffer();
    t_force();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule